// File: doc/BRIEF.md
# Per-VLAN Spanning Tree Gate

This block holds a spanning tree state for every pair of ingress port and VLAN ID, plus a learning policy for every port. Two configuration write ports load them. One sets the 2-bit state of a single port/VLAN pair. The other sets the learning mode of a single port.

For every ingress frame the pipeline presents the frame's port and VLAN ID. It also presents one flag from its address lookup: whether the frame's source MAC is already known on some other port. One cycle later the block returns three decisions: learn the source address, forward the frame, or discard it.

The block does no address lookup and holds no frame data. It only stores state and makes the per-frame decision with a fixed latency of one cycle.

Top module: `vlan_stp_gate`

## Requirements
- R1: After reset every port/VLAN entry holds the discarding state (code 1) and every port's learning mode is disabled (code 0), so every lookup returns learn=0, fwd=0, drop=1.
- R2: The state codes are 1 = discarding, 2 = learning and 3 = forwarding.
  - Discarding gives learn=0 and fwd=0.
  - Learning permits learning but never forwards.
  - Forwarding permits learning and forwards.
- R3: A state write with code 0 leaves the stored state of the addressed entry unchanged.
- R4: The learning mode codes are 0 = disabled, 2 = enabled and 3 = security. Code 1 is reserved and behaves exactly like disabled.
- R5: learn_o is 1 only when the entry's state is learning or forwarding and the port's mode is enabled.
- R6: In security mode the port never learns.
  - A frame whose source MAC is flagged as known on another port is discarded, even in the forwarding state.
  - An unflagged frame is forwarded according to the state alone.
- R7: Whenever a decision is valid, exactly one of fwd_o and drop_o is 1.
- R8: vld_o and the decisions appear exactly one cycle after req_i. In any cycle not preceded by a request, vld_o, learn_o, fwd_o and drop_o are all 0.
- R9: A configuration write in the same cycle as a lookup does not affect that lookup. It takes effect from the next lookup.
- R10: Entries are indexed by the port and VLAN ID together. A write to one pair leaves every other pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_we_i | input | 1 | State write strobe |
| st_port_i | input | PORT_W | State write port |
| st_vid_i | input | VID_W | State write VLAN ID |
| st_code_i | input | 2 | State write code (0 = keep) |
| lm_we_i | input | 1 | Learning mode write strobe |
| lm_port_i | input | PORT_W | Learning mode write port |
| lm_mode_i | input | 2 | Learning mode code |
| req_i | input | 1 | Frame decision request |
| req_port_i | input | PORT_W | Frame ingress port |
| req_vid_i | input | VID_W | Frame VLAN ID |
| req_foreign_i | input | 1 | Source MAC known on another port |
| vld_o | output | 1 | Decision valid |
| learn_o | output | 1 | Learn source address |
| fwd_o | output | 1 | Forward frame |
| drop_o | output | 1 | Discard frame |

## Verification
The hardest situation to bring about is a state write that hits the exact entry being looked up in the same cycle, since the lookup must still see the old state.

The stimulus makes this happen in two ways:
- A directed case drives the write and the lookup to the same pair in one cycle, then looks the pair up again.
- The random phase draws most VLAN IDs from a set of four values over a few ports, so writes and lookups often collide.

Security mode with a flagged frame in the forwarding state is also driven directly and at random, since a single bit of the port's mode overrides the state there.

// File: rtl/stpg_pkg.sv
package stpg_pkg;
  typedef enum logic [1:0] {
    STP_KEEP  = 2'd0,
    STP_DISC  = 2'd1,
    STP_LEARN = 2'd2,
    STP_FWD   = 2'd3
  } stp_state_e;

  typedef enum logic [1:0] {
    LM_OFF  = 2'd0,
    LM_RSVD = 2'd1,
    LM_ON   = 2'd2,
    LM_SEC  = 2'd3
  } lrn_mode_e;
endpackage

// File: rtl/stpg_state_table.sv
module stpg_state_table
  import stpg_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  stp_state_e       wr_code_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output stp_state_e       rd_state_o
);
  localparam int DEPTH = 1 << IDX_W;

  stp_state_e mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= STP_DISC;
    end else if (we_i && wr_code_i != STP_KEEP) begin
      mem_q[wr_idx_i] <= wr_code_i;
    end
  end

  assign rd_state_o = mem_q[rd_idx_i];

  // R3: keep code must not alter the addressed entry
  a_r3_keep_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_code_i == STP_KEEP) |=> (mem_q[$past(wr_idx_i)] == $past(mem_q[wr_idx_i])));

  // R1/R3: code 0 is never stored, so reads never return it
  a_r1_no_keep_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_state_o != STP_KEEP);
endmodule

// File: rtl/stpg_learn_cfg.sv
module stpg_learn_cfg
  import stpg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  lrn_mode_e         wr_mode_i,
  input  logic [PORT_W-1:0] rd_port_i,
  output lrn_mode_e         rd_mode_o
);
  lrn_mode_e mode_q [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q[p] <= LM_OFF;
      else if (we_i && wr_port_i == PORT_W'(p)) mode_q[p] <= wr_mode_i;
    end
  end

  lrn_mode_e raw_mode;

  always_comb begin
    raw_mode = LM_OFF;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_port_i == PORT_W'(p)) raw_mode = mode_q[p];
  end

  // reserved code behaves as disabled
  assign rd_mode_o = (raw_mode == LM_RSVD) ? LM_OFF : raw_mode;

  // R4: reserved code never leaves this block
  a_r4_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mode_o != LM_RSVD);
endmodule

// File: rtl/stpg_decide.sv
module stpg_decide
  import stpg_pkg::*;
(
  input  stp_state_e state_i,
  input  lrn_mode_e  mode_i,
  input  logic       foreign_i,
  output logic       learn_o,
  output logic       fwd_o,
  output logic       drop_o
);
  logic st_lrn_ok;
  logic sec_bad;

  assign st_lrn_ok = (state_i == STP_LEARN) || (state_i == STP_FWD);
  assign sec_bad   = (mode_i == LM_SEC) && foreign_i;
  assign learn_o   = st_lrn_ok && (mode_i == LM_ON);
  assign fwd_o     = (state_i == STP_FWD) && !sec_bad;
  assign drop_o    = !fwd_o;
endmodule

// File: rtl/vlan_stp_gate.sv
module vlan_stp_gate
  import stpg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int VID_W     = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_we_i,
  input  logic [PORT_W-1:0] st_port_i,
  input  logic [VID_W-1:0]  st_vid_i,
  input  logic [1:0]        st_code_i,
  input  logic              lm_we_i,
  input  logic [PORT_W-1:0] lm_port_i,
  input  logic [1:0]        lm_mode_i,
  input  logic              req_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [VID_W-1:0]  req_vid_i,
  input  logic              req_foreign_i,
  output logic              vld_o,
  output logic              learn_o,
  output logic              fwd_o,
  output logic              drop_o
);
  localparam int IDX_W = PORT_W + VID_W;

  stp_state_e lk_state;
  lrn_mode_e  lk_mode;
  logic       d_learn, d_fwd, d_drop;

  stpg_state_table #(.IDX_W(IDX_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (st_we_i),
    .wr_idx_i   ({st_port_i, st_vid_i}),
    .wr_code_i  (stp_state_e'(st_code_i)),
    .rd_idx_i   ({req_port_i, req_vid_i}),
    .rd_state_o (lk_state)
  );

  stpg_learn_cfg #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (lm_we_i),
    .wr_port_i (lm_port_i),
    .wr_mode_i (lrn_mode_e'(lm_mode_i)),
    .rd_port_i (req_port_i),
    .rd_mode_o (lk_mode)
  );

  stpg_decide u_dec (
    .state_i   (lk_state),
    .mode_i    (lk_mode),
    .foreign_i (req_foreign_i),
    .learn_o   (d_learn),
    .fwd_o     (d_fwd),
    .drop_o    (d_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      learn_o <= 1'b0;
      fwd_o   <= 1'b0;
      drop_o  <= 1'b0;
    end else begin
      vld_o   <= req_i;
      learn_o <= req_i && d_learn;
      fwd_o   <= req_i && d_fwd;
      drop_o  <= req_i && d_drop;
    end
  end

  // R8: fixed one-cycle latency
  a_r8_lat_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  a_r8_lat_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> !(learn_o || fwd_o || drop_o));

  // R7
  a_r7_one_of: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (fwd_o != drop_o));

  // R5
  a_r5_learn_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && lk_mode != LM_ON) |=> !learn_o);
  a_r5_learn_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && lk_state == STP_DISC) |=> (!learn_o && !fwd_o));

  // R6
  a_r6_sec_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && lk_mode == LM_SEC && req_foreign_i) |=> (drop_o && !learn_o));
endmodule

// File: tb/sim_vlan_stp_gate.sv
module sim_vlan_stp_gate;
  localparam int NP = 4;
  localparam int VW = 8;
  localparam int PW = 2;
  localparam int NV = 1 << VW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic st_we_i = 1'b0, lm_we_i = 1'b0, req_i = 1'b0, req_foreign_i = 1'b0;
  logic [PW-1:0] st_port_i = '0, lm_port_i = '0, req_port_i = '0;
  logic [VW-1:0] st_vid_i = '0, req_vid_i = '0;
  logic [1:0] st_code_i = '0, lm_mode_i = '0;
  logic vld_o, learn_o, fwd_o, drop_o;

  always #4 clk_i = ~clk_i;

  vlan_stp_gate #(.NUM_PORTS(NP), .VID_W(VW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_st [NP][NV];
  int m_md [NP];
  logic [3:0] exp_q = 4'b0;
  string tag_q = "R1";

  function automatic logic [2:0] decide(int st, int md, bit foreign);
    logic lrn, fwd;
    lrn = (st == 2 || st == 3) && md == 2;
    fwd = (st == 3) && !(md == 3 && foreign);
    return {lrn, fwd, !fwd};
  endfunction

  task automatic step(bit sw, int sp, int sv, int sc, bit mw, int mp, int mm,
                      bit rq, int rp, int rv, bit rf, string tag);
    logic [3:0] act, e;
    @(negedge clk_i);
    act = {vld_o, learn_o, fwd_o, drop_o};
    checks++;
    if (act !== exp_q) begin
      errors++;
      $display("FAIL %s: {vld,learn,fwd,drop} got %b expected %b", tag_q, act, exp_q);
    end
    if (vld_o && (fwd_o == drop_o)) begin
      errors++;
      $display("FAIL R7: fwd %b drop %b expected complementary", fwd_o, drop_o);
    end
    st_we_i = sw; st_port_i = PW'(sp); st_vid_i = VW'(sv); st_code_i = 2'(sc);
    lm_we_i = mw; lm_port_i = PW'(mp); lm_mode_i = 2'(mm);
    req_i = rq; req_port_i = PW'(rp); req_vid_i = VW'(rv); req_foreign_i = rf;
    e = rq ? {1'b1, decide(m_st[rp][rv], m_md[rp], rf)} : 4'b0;
    if (sw && sc != 0) m_st[sp][sv] = sc;
    if (mw) m_md[mp] = mm;
    exp_q = e;
    tag_q = tag;
  endtask

  task automatic look(int p, int v, bit f, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, p, v, f, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_md[p] = 0;
      for (int v = 0; v < NV; v++) m_st[p][v] = 1;
    end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state at both ends of the index space
    look(0, 0, 0, "R1");
    look(NP-1, NV-1, 1, "R1");
    look(2, 77, 0, "R1");

    // R2/R5: learning state with learning enabled
    step(0, 0, 0, 0, 1, 1, 2, 0, 0, 0, 0, "R8");
    step(1, 1, 5, 2, 0, 0, 0, 0, 0, 0, 0, "R8");
    look(1, 5, 0, "R2");

    // R2: forwarding state
    step(1, 1, 5, 3, 0, 0, 0, 0, 0, 0, 0, "R8");
    look(1, 5, 0, "R2");

    // R3: code 0 leaves the entry as forwarding
    step(1, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    look(1, 5, 0, "R3");

    // R4: reserved mode acts as disabled
    step(0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R8");
    look(1, 5, 0, "R4");

    // R6: security mode, flagged and unflagged source
    step(0, 0, 0, 0, 1, 1, 3, 0, 0, 0, 0, "R8");
    look(1, 5, 1, "R6");
    look(1, 5, 0, "R6");

    // R9: write and lookup to the same pair in one cycle
    step(1, 2, 7, 3, 0, 0, 0, 1, 2, 7, 0, "R9");
    look(2, 7, 0, "R9");

    // R10: neighbours of a written pair unchanged
    step(1, 3, 10, 3, 0, 0, 0, 0, 0, 0, 0, "R8");
    look(3, 11, 0, "R10");
    look(2, 10, 0, "R10");
    look(3, 10, 0, "R10");

    // R8: idle cycle yields all zero
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");

    // random mix concentrated on a few VLAN IDs
    for (int i = 0; i < 5000; i++) begin
      int sv, rv;
      sv = ($urandom % 5 == 0) ? int'($urandom % NV) : int'($urandom % 4);
      rv = ($urandom % 5 == 0) ? int'($urandom % NV) : int'($urandom % 4);
      step($urandom % 3 == 0, $urandom % NP, sv, $urandom % 4,
           $urandom % 8 == 0, $urandom % NP, $urandom % 4,
           $urandom % 4 != 0, $urandom % NP, rv, $urandom % 2,
           "R2 R5 R6 R9 R10");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule